// File: doc/BRIEF.md
# Per-CPU Interrupt Wakeup Generator

This block lives in an always-on domain, in front of a shared interrupt controller. It receives a vector of level-sensitive shared peripheral interrupt lines. It passes them on to the interrupt controller unchanged. For each of several CPUs it keeps a separate enable mask, with one bit per interrupt line. Software reads and writes these masks as 32-bit registers over a simple register bus.

Each interrupt line goes through a two-flop synchronizer. The synchronized lines are combined with each CPU's mask. When any enabled line is active for a CPU, that CPU's wakeup output is raised.

A standby controller asks permission for a CPU to go idle by raising that CPU's idle request. The block grants the request with an idle acknowledge only while no enabled interrupt is pending for that CPU. It withdraws the grant at once if the request falls or an enabled interrupt appears.

Top module: `wkg_top`

## Requirements
- R1: After reset every enable register reads 0, and every `wake` and `idle_ack` bit is 0.
- R2: `irq_out` equals `irq_in` in the same cycle, with no register on the path.
- R3: A bus write (`bus_sel`=1, `bus_wr`=1) to byte offset `c*0x400 + b*4` (with c < 2 and b < 4) stores `bus_wdata` into the enable register of CPU c, bank b, on that clock edge. Bit k of that register enables interrupt `32*b + k`, so interrupt n sits in bank n>>5 at bit n mod 32.
- R4: While `bus_sel`=1 and `bus_wr`=0, `bus_rdata` combinationally returns the addressed enable register. At any other time, including a read of an offset that is not mapped, `bus_rdata` is 0.
- R5: A write to an unmapped offset changes no enable register.
- R6: Writing 0xFFFFFFFF to a bank enables all 32 of its interrupts, and writing 0 disables all 32.
- R7: `wake[c]` is 1 exactly when some interrupt is active in the synchronized input and is enabled in CPU c's mask. A change on `irq_in` reaches `wake` after the second rising clock edge.
- R8: The two CPUs' masks are independent. A write to one CPU's register never alters the other CPU's registers or wakeup output.
- R9: `idle_ack[c]` rises at the first rising edge at which `idle_req[c]` was 1 and `wake[c]` was 0 before the edge, provided both still hold after the edge.
- R10: `idle_ack[c]` is 0 in any cycle in which `idle_req[c]` is 0 or `wake[c]` is 1, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 128 | Level-sensitive interrupt lines |
| irq_out | output | 128 | Lines forwarded to the interrupt controller |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| idle_req | input | 2 | Per-CPU idle request from the standby controller |
| idle_ack | output | 2 | Per-CPU idle grant |
| wake | output | 2 | Per-CPU wakeup event |

## Verification
The results fall due at different times:
- `irq_out` and read data are combinational. The bench samples them 1 ns after it drives the inputs.
- A register write takes effect at the next rising edge. The bench samples read-back after that edge.
- `wake` follows `irq_in` after two rising edges. The bench therefore checks it 1 ns after the second edge following the change.
- An idle grant is due 1 ns after the first edge that sees a request with no pending interrupt. Its withdrawal is due 1 ns after the request falls or a pending interrupt becomes visible.

Because every input is driven on the falling edge and every output is sampled between edges, no check races the clock.

// File: rtl/wkg_pkg.sv
package wkg_pkg;
  // Bank index holding interrupt n
  function automatic int unsigned irq_bank(input int unsigned n);
    return n >> 5;
  endfunction

  // Bit position of interrupt n inside its bank
  function automatic int unsigned irq_bit(input int unsigned n);
    return n & 31;
  endfunction

  // Byte offset of the enable register for a CPU and bank
  function automatic int unsigned reg_offset(input int unsigned cpu,
                                             input int unsigned bank,
                                             input int unsigned stride);
    return cpu * stride + bank * 4;
  endfunction
endpackage

// File: rtl/wkg_sync.sv
module wkg_sync #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/wkg_mask_bank.sv
module wkg_mask_bank #(
  parameter int NUM_BANK = 4,
  parameter int DATA_W   = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_BANK-1:0]        wr_hit,
  input  logic [DATA_W-1:0]          wdata,
  output logic [NUM_BANK*DATA_W-1:0] mask
);
  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mask[b*DATA_W +: DATA_W] <= '0;
      else if (wr_hit[b]) mask[b*DATA_W +: DATA_W] <= wdata;
    end
  end
endmodule

// File: rtl/wkg_idle_hs.sv
module wkg_idle_hs (
  input  logic clk,
  input  logic rst_n,
  input  logic idle_req,
  input  logic pending,
  output logic idle_ack
);
  logic grant_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grant_q <= 1'b0;
    else        grant_q <= idle_req & ~pending;
  end

  // Registered grant, withdrawn at once on request drop or pending interrupt
  assign idle_ack = grant_q & idle_req & ~pending;
endmodule

// File: rtl/wkg_top.sv
module wkg_top
  import wkg_pkg::*;
#(
  parameter int NUM_CPU    = 2,
  parameter int NUM_IRQ    = 128,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 12,
  parameter int CPU_STRIDE = 'h400
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  output logic [NUM_IRQ-1:0] irq_out,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_CPU-1:0] idle_req,
  output logic [NUM_CPU-1:0] idle_ack,
  output logic [NUM_CPU-1:0] wake
);
  localparam int NUM_BANK = NUM_IRQ / DATA_W;

  logic [NUM_IRQ-1:0]                irq_sync;
  logic [NUM_CPU-1:0][NUM_IRQ-1:0]   cpu_mask;
  logic [NUM_CPU-1:0][NUM_BANK-1:0]  reg_hit;
  logic [NUM_CPU-1:0]                pending;
  logic                              bus_write;
  logic                              bus_read;

  assign irq_out   = irq_in;
  assign bus_write = bus_sel & bus_wr;
  assign bus_read  = bus_sel & ~bus_wr;

  wkg_sync #(.W(NUM_IRQ)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (irq_in),
    .q     (irq_sync)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    for (genvar b = 0; b < NUM_BANK; b++) begin : g_dec
      assign reg_hit[c][b] =
        (bus_addr == ADDR_W'(reg_offset(c, b, CPU_STRIDE)));
    end

    wkg_mask_bank #(.NUM_BANK(NUM_BANK), .DATA_W(DATA_W)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hit (reg_hit[c] & {NUM_BANK{bus_write}}),
      .wdata  (bus_wdata),
      .mask   (cpu_mask[c])
    );

    assign pending[c] = |(irq_sync & cpu_mask[c]);

    wkg_idle_hs u_idle (
      .clk      (clk),
      .rst_n    (rst_n),
      .idle_req (idle_req[c]),
      .pending  (pending[c]),
      .idle_ack (idle_ack[c])
    );
  end

  assign wake = pending;

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NUM_CPU; c++) begin
      for (int b = 0; b < NUM_BANK; b++) begin
        if (bus_read && reg_hit[c][b])
          bus_rdata = bus_rdata | cpu_mask[c][b*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/wkg_chk.sv
module wkg_chk
  import wkg_pkg::*;
#(
  parameter int NUM_CPU    = 2,
  parameter int NUM_IRQ    = 128,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 12,
  parameter int CPU_STRIDE = 'h400
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_IRQ-1:0] irq_in,
  input logic [NUM_IRQ-1:0] irq_out,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic [NUM_CPU-1:0] idle_req,
  input logic [NUM_CPU-1:0] idle_ack,
  input logic [NUM_CPU-1:0] wake,
  input logic [NUM_CPU-1:0] pending
);
  localparam int NUM_BANK = NUM_IRQ / DATA_W;

  logic mapped;
  logic past_ok;

  always_comb begin
    mapped = 1'b0;
    for (int c = 0; c < NUM_CPU; c++)
      for (int b = 0; b < NUM_BANK; b++)
        if (bus_addr == ADDR_W'(reg_offset(c, b, CPU_STRIDE))) mapped = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  p_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == irq_in);

  p_unmapped_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && !mapped) |-> bus_rdata == '0);

  p_idle_read_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> bus_rdata == '0);

  p_quiet_no_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(irq_in, 2) == '0) |-> wake == '0);

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_c
    p_wake_is_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wake[c] == pending[c]);

    p_ack_needs_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
      idle_ack[c] |-> idle_req[c]);

    p_ack_no_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
      idle_ack[c] |-> !wake[c]);

    p_ack_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && idle_req[c] && !wake[c] && $past(idle_req[c]) && !$past(wake[c]))
      |-> idle_ack[c]);

    p_ack_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $rose(idle_ack[c])) |-> $past(idle_req[c]));
  end
endmodule

bind wkg_top wkg_chk #(
  .NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W),
  .ADDR_W(ADDR_W), .CPU_STRIDE(CPU_STRIDE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_in    (irq_in),
  .irq_out   (irq_out),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .idle_req  (idle_req),
  .idle_ack  (idle_ack),
  .wake      (wake),
  .pending   (pending)
);

// File: tb/wkg_top_tb.sv
module wkg_top_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] irq_in = '0;
  logic [127:0] irq_out;
  logic         bus_sel = 1'b0;
  logic         bus_wr = 1'b0;
  logic [11:0]  bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [1:0]   idle_req = '0;
  logic [1:0]   idle_ack;
  logic [1:0]   wake;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  logic [31:0] model [2][4];

  always #10 clk = ~clk;

  wkg_top u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .irq_out(irq_out),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .idle_req(idle_req), .idle_ack(idle_ack), .wake(wake)
  );

  function automatic logic [11:0] addr_of(int c, int b);
    return 12'(c * 1024 + b * 4);
  endfunction

  function automatic logic exp_wake(logic [127:0] irq, int c);
    logic hit = 1'b0;
    for (int n = 0; n < 128; n++)
      if (irq[n] && model[c][n / 32][n % 32]) hit = 1'b1;
    return hit;
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic set_mask(int c, int b, logic [31:0] d);
    bus_write(addr_of(c, b), d);
    model[c][b] = d;
  endtask

  task automatic check_all_regs(string req);
    logic [31:0] d;
    for (int c = 0; c < 2; c++)
      for (int b = 0; b < 4; b++) begin
        bus_read(addr_of(c, b), d);
        check(req, 128'(d), 128'(model[c][b]));
      end
  endtask

  task automatic drive_irq_check_wake(logic [127:0] v, string req);
    @(negedge clk);
    irq_in = v;
    #1 check("R2", irq_out, v);
    @(posedge clk); @(posedge clk); #1;
    check(req, 128'(wake), 128'({exp_wake(v, 1), exp_wake(v, 0)}));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    logic [127:0] v;
    void'($urandom(32'h5eed1234));
    for (int c = 0; c < 2; c++) for (int b = 0; b < 4; b++) model[c][b] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    #1 check("R1", 128'(wake), 128'(0));
    check("R1", 128'(idle_ack), 128'(0));
    check_all_regs("R1");

    // R4 no access -> zero data
    #1 check("R4", 128'(bus_rdata), 128'(0));

    // R3 write/read each register
    for (int c = 0; c < 2; c++)
      for (int b = 0; b < 4; b++) set_mask(c, b, $urandom());
    check_all_regs("R3");

    // R8 write one CPU only, other unchanged
    set_mask(0, 2, 32'hA5A5_0F0F);
    check_all_regs("R8");

    // R5 / R4 unmapped offsets
    bus_write(12'h010, 32'hFFFF_FFFF);
    bus_write(12'h3FC, 32'hFFFF_FFFF);
    bus_write(12'h410, 32'hFFFF_FFFF);
    bus_write(12'h800, 32'hFFFF_FFFF);
    bus_read(12'h010, d); check("R4", 128'(d), 128'(0));
    bus_read(12'h410, d); check("R4", 128'(d), 128'(0));
    bus_read(12'h802, d); check("R4", 128'(d), 128'(0));
    check_all_regs("R5");

    // R6 all ones / all zeros
    set_mask(1, 3, 32'hFFFF_FFFF);
    set_mask(0, 3, 32'h0);
    drive_irq_check_wake(128'h1 << 127, "R6");
    check("R6", 128'(wake), 128'(2'b10));
    set_mask(1, 3, 32'h0);
    #1 check("R6", 128'(wake), 128'(0));

    // R7 latency: wake must not appear after only one edge
    for (int c = 0; c < 2; c++) for (int b = 0; b < 4; b++) set_mask(c, b, '0);
    set_mask(0, 1, 32'h0000_0010);  // interrupt 36 for CPU0
    @(negedge clk) irq_in = 128'h1 << 36;
    @(posedge clk); #1 check("R7", 128'(wake), 128'(0));
    @(posedge clk); #1 check("R7", 128'(wake), 128'(2'b01));
    drive_irq_check_wake('0, "R7");

    // R7 / R8 random masks and lines
    for (int i = 0; i < 150; i++) begin
      if ($urandom_range(0, 2) == 0)
        set_mask($urandom_range(0, 1), $urandom_range(0, 3), $urandom() & $urandom());
      v = '0;
      for (int k = 0; k < 3; k++) v[$urandom_range(0, 127)] = ($urandom_range(0, 1) == 1);
      drive_irq_check_wake(v, "R7");
    end
    drive_irq_check_wake('0, "R7");

    // R9 / R10 idle handshake
    for (int c = 0; c < 2; c++) for (int b = 0; b < 4; b++) set_mask(c, b, '0);
    set_mask(0, 0, 32'h1);   // interrupt 0 -> CPU0
    set_mask(1, 2, 32'h1);   // interrupt 64 -> CPU1
    @(negedge clk) idle_req = 2'b11;
    #1 check("R9", 128'(idle_ack), 128'(0));
    @(posedge clk); #1 check("R9", 128'(idle_ack), 128'(2'b11));
    @(negedge clk) irq_in = 128'h1;
    @(posedge clk); #1 check("R10", 128'(idle_ack), 128'(2'b11));
    @(posedge clk); #1 check("R10", 128'(idle_ack), 128'(2'b10));
    check("R7", 128'(wake), 128'(2'b01));
    @(negedge clk) irq_in = '0;
    @(posedge clk); @(posedge clk); #1 check("R9", 128'(idle_ack), 128'(2'b10));
    @(posedge clk); #1 check("R9", 128'(idle_ack), 128'(2'b11));
    @(negedge clk) idle_req = 2'b01;
    #1 check("R10", 128'(idle_ack), 128'(2'b01));
    @(negedge clk) irq_in = 128'h1 << 64;
    @(posedge clk); @(posedge clk);
    @(negedge clk) idle_req = 2'b11;
    @(posedge clk); #1 check("R10", 128'(idle_ack), 128'(2'b01));
    check("R8", 128'(wake), 128'(2'b10));
    @(negedge clk) begin idle_req = '0; irq_in = '0; end
    #1 check("R10", 128'(idle_ack), 128'(0));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule